// File: doc/BRIEF.md
# Line-Merging Byte-Enable Arbiter

This block sits between eight load/store units and a cache with 16-byte lines. Each unit posts one access, given as a byte address and a size of 1, 2, 4 or 8 bytes. The block turns that access into a line address and a 16-bit byte-enable mask. An access whose bytes run past the end of its line is stored as two halves. The first half is on the original line. The second half is on the following line and covers the bytes that overflowed.

Once per cycle the block picks one target line. It grants every pending half that lies on that line, ORs their masks into one line-level enable, and reports which unit owns each byte of that enable. When several granted units cover the same byte, the lowest-numbered unit owns it. A unit gets a done pulse in the cycle when its last half is granted. Only after that can the unit post a new access.

Top module: `lsm_merge_unit`

## Requirements
- R1: The size code is 2 bits: 00 means 1 byte, 01 means 2, 10 means 4 and 11 means 8. An accepted access has line address = address >> 4. Its first-half mask sets the bits from offset (address bits 3:0) up to offset+size-1, limited to bit 15.
- R2: If offset+size exceeds 16, the access also produces a second half on line+1. The mask of that half sets bits 0 to offset+size-17. The second half is granted only after the first half has been granted, and never in the same cycle.
- R3: Every pending half whose line equals the selected line is granted in the same cycle. `sel_mask` is the OR of the masks of all granted halves.
- R4: The selected line is the line of the lowest-numbered unit with a pending first half. If no first half is pending, it is the line of the lowest-numbered unit with an eligible second half.
- R5: `grant[u]` is high when any half of unit u is granted. `grant_hi[u]` is high when the granted half is the second half. At most one half per unit is granted in a cycle.
- R6: `done[u]` pulses in the cycle when unit u's last pending half is granted. After that edge `busy[u]` is low.
- R7: An access is captured only at a clock edge where `req_valid[u]` is high and `busy[u]` is low. A request while busy is ignored and does not change that unit's pending halves. A captured access is first granted in the cycle after the capturing edge.
- R8: `byte_owner[3*b+2:3*b]` holds the lowest-numbered granted unit whose granted mask covers byte b. It is 0 for bytes that no granted mask covers.
- R9: `sel_valid` is high exactly when some half is pending. When `sel_valid` is low, `grant` and `sel_mask` are zero. A synchronous active-high reset clears all pending state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 8 | Per-unit access request |
| req_addr | input | 512 | Per-unit byte address, unit u in bits 64u+63:64u |
| req_width | input | 16 | Per-unit size code, unit u in bits 2u+1:2u |
| busy | output | 8 | Unit has a pending half |
| done | output | 8 | Unit's last half granted this cycle |
| sel_valid | output | 1 | A line is selected this cycle |
| sel_line | output | 60 | Selected line address |
| sel_mask | output | 16 | Merged byte enable for the selected line |
| grant | output | 8 | Per-unit grant this cycle |
| grant_hi | output | 8 | Granted half is the second half |
| byte_owner | output | 48 | Per-byte owning unit, 3 bits per byte |

## Verification
The interesting overlap is a split access whose second half is merged in the same cycle as another unit's first half on that same next line. The bench posts a line-crossing access from unit 3 together with an aligned access from unit 6 to the following line. It then expects unit 3's first half alone in cycle one. In cycle two it expects one grant covering unit 6's first half and unit 3's second half, with `grant_hi` set only for unit 3, a merged mask, unit 3 as owner of the shared byte, and done pulses for both units.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

  // Number of bytes for a 2-bit size code: 1, 2, 4, 8
  function automatic logic [3:0] size_bytes(input logic [1:0] code);
    return 4'd1 << code;
  endfunction

  // Byte span of an access, placed at its offset in a two-line window.
  // The low line's bits are the first half; the bits above are the overflow.
  function automatic logic [63:0] span_mask(input logic [7:0] ofs, input logic [1:0] code);
    logic [63:0] base;
    base = (64'd1 << size_bytes(code)) - 64'd1;
    return base << ofs;
  endfunction

endpackage

// File: rtl/lsm_req_slot.sv
module lsm_req_slot #(
  parameter int ADDR_W     = 64,
  parameter int LINE_BYTES = 16,
  localparam int OFS_W     = $clog2(LINE_BYTES),
  localparam int LINE_W    = ADDR_W - OFS_W,
  localparam int SPAN_W    = 2 * LINE_BYTES
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [1:0]            req_width,
  input  logic                  gnt_lo,
  input  logic                  gnt_hi,
  output logic                  busy,
  output logic                  pend_lo,
  output logic                  pend_hi,
  output logic [LINE_W-1:0]     line_lo,
  output logic [LINE_W-1:0]     line_hi,
  output logic [LINE_BYTES-1:0] mask_lo,
  output logic [LINE_BYTES-1:0] mask_hi
);

  logic [SPAN_W-1:0] span;
  logic              accept;

  assign span   = SPAN_W'(lsm_pkg::span_mask(8'(req_addr[OFS_W-1:0]), req_width));
  assign busy   = pend_lo | pend_hi;
  assign accept = req_valid & ~busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_lo <= 1'b0;
      pend_hi <= 1'b0;
      line_lo <= '0;
      line_hi <= '0;
      mask_lo <= '0;
      mask_hi <= '0;
    end else if (accept) begin
      pend_lo <= 1'b1;
      pend_hi <= |span[SPAN_W-1:LINE_BYTES];
      line_lo <= req_addr[ADDR_W-1:OFS_W];
      line_hi <= req_addr[ADDR_W-1:OFS_W] + LINE_W'(1);
      mask_lo <= span[LINE_BYTES-1:0];
      mask_hi <= span[SPAN_W-1:LINE_BYTES];
    end else begin
      if (gnt_lo) pend_lo <= 1'b0;
      if (gnt_hi) pend_hi <= 1'b0;
    end
  end

  AST_HI_AFTER_LO: assert property (@(posedge clk) disable iff (rst)
    gnt_hi |-> !pend_lo); // R2

  AST_BUSY_IGNORES_REQ: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(line_lo) && $stable(mask_lo) && $stable(mask_hi))); // R7

endmodule

// File: rtl/lsm_line_pick.sv
module lsm_line_pick #(
  parameter int NUM_UNITS = 8,
  parameter int LINE_W    = 60
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_UNITS-1:0] pend_lo,
  input  logic [NUM_UNITS-1:0] pend_hi,
  input  logic [LINE_W-1:0] line_lo [NUM_UNITS],
  input  logic [LINE_W-1:0] line_hi [NUM_UNITS],
  output logic              sel_valid,
  output logic [LINE_W-1:0] sel_line,
  output logic [NUM_UNITS-1:0] gnt_lo,
  output logic [NUM_UNITS-1:0] gnt_hi
);

  logic [NUM_UNITS-1:0] elig_hi;
  logic                 found;

  assign elig_hi = pend_hi & ~pend_lo;

  always_comb begin
    found    = 1'b0;
    sel_line = '0;
    for (int i = 0; i < NUM_UNITS; i++) begin
      if (!found && pend_lo[i]) begin
        found    = 1'b1;
        sel_line = line_lo[i];
      end
    end
    for (int i = 0; i < NUM_UNITS; i++) begin
      if (!found && elig_hi[i]) begin
        found    = 1'b1;
        sel_line = line_hi[i];
      end
    end
  end

  assign sel_valid = found;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_match
    assign gnt_lo[u] = pend_lo[u] && (line_lo[u] == sel_line);
    assign gnt_hi[u] = elig_hi[u] && (line_hi[u] == sel_line);
  end

  AST_SEL_GRANTS_SOME: assert property (@(posedge clk) disable iff (rst)
    sel_valid |-> ((gnt_lo | gnt_hi) != '0)); // R3

  AST_ONE_HALF_PER_UNIT: assert property (@(posedge clk) disable iff (rst)
    (gnt_lo & gnt_hi) == '0); // R5

  AST_FIRST_HALF_PRIORITY: assert property (@(posedge clk) disable iff (rst)
    (pend_lo != '0) |-> (gnt_lo != '0)); // R4

endmodule

// File: rtl/lsm_byte_owner.sv
module lsm_byte_owner #(
  parameter int NUM_UNITS  = 8,
  parameter int LINE_BYTES = 16,
  localparam int UIDX_W    = $clog2(NUM_UNITS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [LINE_BYTES-1:0] gmask [NUM_UNITS],
  output logic [LINE_BYTES-1:0] merged,
  output logic [UIDX_W-1:0]     owner [LINE_BYTES]
);

  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
    always_comb begin
      merged[b] = 1'b0;
      owner[b]  = '0;
      for (int u = NUM_UNITS - 1; u >= 0; u--) begin
        if (gmask[u][b]) begin
          merged[b] = 1'b1;
          owner[b]  = UIDX_W'(u);
        end
      end
    end

    AST_OWNER_COVERS: assert property (@(posedge clk) disable iff (rst)
      merged[b] |-> gmask[owner[b]][b]); // R8
  end

endmodule

// File: rtl/lsm_merge_unit.sv
module lsm_merge_unit #(
  parameter int NUM_UNITS  = 8,
  parameter int ADDR_W     = 64,
  parameter int LINE_BYTES = 16,
  localparam int OFS_W     = $clog2(LINE_BYTES),
  localparam int LINE_W    = ADDR_W - OFS_W,
  localparam int UIDX_W    = $clog2(NUM_UNITS)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_UNITS-1:0]           req_valid,
  input  logic [NUM_UNITS*ADDR_W-1:0]    req_addr,
  input  logic [NUM_UNITS*2-1:0]         req_width,
  output logic [NUM_UNITS-1:0]           busy,
  output logic [NUM_UNITS-1:0]           done,
  output logic                           sel_valid,
  output logic [LINE_W-1:0]              sel_line,
  output logic [LINE_BYTES-1:0]          sel_mask,
  output logic [NUM_UNITS-1:0]           grant,
  output logic [NUM_UNITS-1:0]           grant_hi,
  output logic [LINE_BYTES*UIDX_W-1:0]   byte_owner
);

  logic [NUM_UNITS-1:0]  pend_lo, pend_hi, gnt_lo, gnt_hi;
  logic [LINE_W-1:0]     line_lo [NUM_UNITS];
  logic [LINE_W-1:0]     line_hi [NUM_UNITS];
  logic [LINE_BYTES-1:0] mask_lo [NUM_UNITS];
  logic [LINE_BYTES-1:0] mask_hi [NUM_UNITS];
  logic [LINE_BYTES-1:0] gmask   [NUM_UNITS];
  logic [UIDX_W-1:0]     owner   [LINE_BYTES];

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    lsm_req_slot #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_slot (
      .clk       (clk),
      .rst       (rst),
      .req_valid (req_valid[u]),
      .req_addr  (req_addr[u*ADDR_W +: ADDR_W]),
      .req_width (req_width[u*2 +: 2]),
      .gnt_lo    (gnt_lo[u]),
      .gnt_hi    (gnt_hi[u]),
      .busy      (busy[u]),
      .pend_lo   (pend_lo[u]),
      .pend_hi   (pend_hi[u]),
      .line_lo   (line_lo[u]),
      .line_hi   (line_hi[u]),
      .mask_lo   (mask_lo[u]),
      .mask_hi   (mask_hi[u])
    );

    assign gmask[u] = gnt_lo[u] ? mask_lo[u] : (gnt_hi[u] ? mask_hi[u] : '0);
    // last half: first half granted with no second half left, or second half granted
    assign done[u]  = (gnt_lo[u] & ~pend_hi[u]) | gnt_hi[u];

    AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (rst)
      done[u] |=> !busy[u]); // R6

    AST_PENDING_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (busy[u] && !done[u]) |=> busy[u]); // R6
  end

  lsm_line_pick #(.NUM_UNITS(NUM_UNITS), .LINE_W(LINE_W)) u_pick (
    .clk       (clk),
    .rst       (rst),
    .pend_lo   (pend_lo),
    .pend_hi   (pend_hi),
    .line_lo   (line_lo),
    .line_hi   (line_hi),
    .sel_valid (sel_valid),
    .sel_line  (sel_line),
    .gnt_lo    (gnt_lo),
    .gnt_hi    (gnt_hi)
  );

  lsm_byte_owner #(.NUM_UNITS(NUM_UNITS), .LINE_BYTES(LINE_BYTES)) u_owner (
    .clk    (clk),
    .rst    (rst),
    .gmask  (gmask),
    .merged (sel_mask),
    .owner  (owner)
  );

  assign grant    = gnt_lo | gnt_hi;
  assign grant_hi = gnt_hi;

  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_flat
    assign byte_owner[b*UIDX_W +: UIDX_W] = owner[b];
  end

  AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
    !sel_valid |-> (grant == '0 && sel_mask == '0)); // R9

  AST_MASK_WHEN_VALID: assert property (@(posedge clk) disable iff (rst)
    sel_valid |-> (sel_mask != '0)); // R3

endmodule

// File: tb/lsm_merge_unit_bench.sv
module lsm_merge_unit_bench;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [7:0]   req_valid = '0;
  logic [511:0] req_addr  = '0;
  logic [15:0]  req_width = '0;
  logic [7:0]   busy, done, grant, grant_hi;
  logic         sel_valid;
  logic [59:0]  sel_line;
  logic [15:0]  sel_mask;
  logic [47:0]  byte_owner;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  lsm_merge_unit u_lsm_merge_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_width(req_width), .busy(busy), .done(done), .sel_valid(sel_valid),
    .sel_line(sel_line), .sel_mask(sel_mask), .grant(grant),
    .grant_hi(grant_hi), .byte_owner(byte_owner)
  );

  typedef struct packed {
    logic [2:0]  u;
    logic [63:0] a;
    logic [1:0]  w;
    logic [15:0] lo;
    logic [15:0] hi;
  } vec_t;

  localparam vec_t VT [8] = '{
    '{3'd0, 64'h1000, 2'd0, 16'h0001, 16'h0000},
    '{3'd1, 64'h1003, 2'd1, 16'h0018, 16'h0000},
    '{3'd2, 64'h100C, 2'd2, 16'hF000, 16'h0000},
    '{3'd3, 64'h1008, 2'd3, 16'hFF00, 16'h0000},
    '{3'd4, 64'h100F, 2'd1, 16'h8000, 16'h0001},
    '{3'd5, 64'h100D, 2'd3, 16'hE000, 16'h001F},
    '{3'd6, 64'h100E, 2'd2, 16'hC000, 16'h0003},
    '{3'd7, 64'h1FFF_FFFF_FFFF_FFF9, 2'd3, 16'hFE00, 16'h0001}
  };

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic post(input int u, input logic [63:0] a, input logic [1:0] w);
    req_valid[u] = 1'b1;
    req_addr[u*64 +: 64] = a;
    req_width[u*2 +: 2] = w;
  endtask

  // inputs set after a falling edge; the rising edge captures; checks one falling edge later
  task automatic launch();
    @(negedge clk);
    req_valid = '0;
    #1;
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  function automatic logic [2:0] own(input int b);
    return byte_owner[b*3 +: 3];
  endfunction

  initial begin
    repeat (400) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R9", "reset sel_valid", 64'(sel_valid), 64'd0);
    chk("R9", "reset busy", 64'(busy), 64'd0);
    chk("R9", "reset grant", 64'(grant), 64'd0);

    // table walk: single accesses, R1 masks and R2 splits
    for (int k = 0; k < 8; k++) begin
      v = VT[k];
      @(negedge clk);
      post(int'(v.u), v.a, v.w);
      launch();
      chk("R7", "captured busy", 64'(busy), 64'(8'd1 << v.u));
      chk("R1", "line", 64'(sel_line), 64'(v.a[63:4]));
      chk("R1", "first mask", 64'(sel_mask), 64'(v.lo));
      chk("R5", "grant", 64'(grant), 64'(8'd1 << v.u));
      chk("R5", "grant_hi first", 64'(grant_hi), 64'd0);
      chk("R6", "done first", 64'(done), (v.hi == 16'h0) ? 64'(8'd1 << v.u) : 64'd0);
      if (v.hi != 16'h0) begin
        step();
        chk("R2", "second line", 64'(sel_line), 64'(v.a[63:4] + 60'd1));
        chk("R2", "second mask", 64'(sel_mask), 64'(v.hi));
        chk("R5", "grant_hi second", 64'(grant_hi), 64'(8'd1 << v.u));
        chk("R6", "done second", 64'(done), 64'(8'd1 << v.u));
      end
      step();
      chk("R9", "idle after", 64'(sel_valid), 64'd0);
    end

    // merge and overlap ownership: R3, R4, R8
    @(negedge clk);
    post(2, 64'h2000, 2'd3);
    post(5, 64'h2006, 2'd2);
    post(1, 64'h3000, 2'd0);
    launch();
    chk("R4", "lowest first", 64'(sel_line), 64'h300);
    chk("R4", "lowest grant", 64'(grant), 64'h02);
    step();
    chk("R3", "merged line", 64'(sel_line), 64'h200);
    chk("R3", "merged mask", 64'(sel_mask), 64'h03FF);
    chk("R3", "merged grant", 64'(grant), 64'h24);
    chk("R8", "owner byte6", 64'(own(6)), 64'd2);
    chk("R8", "owner byte8", 64'(own(8)), 64'd5);
    chk("R8", "owner byte12", 64'(own(12)), 64'd0);
    chk("R6", "merged done", 64'(done), 64'h24);
    step();

    // second half merged with another unit's first half: R2, R3, R5, R8
    @(negedge clk);
    post(3, 64'h400E, 2'd2);
    post(6, 64'h4010, 2'd0);
    launch();
    chk("R2", "split first only", 64'(grant), 64'h08);
    chk("R2", "split first mask", 64'(sel_mask), 64'hC000);
    chk("R6", "no done yet", 64'(done), 64'h00);
    step();
    chk("R3", "mixed line", 64'(sel_line), 64'h401);
    chk("R3", "mixed grant", 64'(grant), 64'h48);
    chk("R5", "mixed grant_hi", 64'(grant_hi), 64'h08);
    chk("R3", "mixed mask", 64'(sel_mask), 64'h0003);
    chk("R8", "mixed owner byte0", 64'(own(0)), 64'd3);
    chk("R6", "mixed done", 64'(done), 64'h48);
    step();

    // first halves beat a pending second half: R4
    @(negedge clk);
    post(0, 64'h500F, 2'd1);
    post(7, 64'h6000, 2'd0);
    launch();
    chk("R4", "prio c1", 64'(sel_line), 64'h500);
    step();
    chk("R4", "prio c2 first half wins", 64'(sel_line), 64'h600);
    chk("R4", "prio c2 grant", 64'(grant), 64'h80);
    step();
    chk("R4", "prio c3 second half", 64'(sel_line), 64'h501);
    chk("R5", "prio c3 grant_hi", 64'(grant_hi), 64'h01);
    step();

    // request while busy is ignored: R7
    @(negedge clk);
    post(3, 64'h800F, 2'd1);
    launch();
    post(3, 64'h9000, 2'd3);
    chk("R7", "busy c1 line", 64'(sel_line), 64'h800);
    step();
    req_valid = '0;
    chk("R7", "ignored line", 64'(sel_line), 64'h801);
    chk("R7", "ignored mask", 64'(sel_mask), 64'h0001);
    step();
    chk("R7", "ignored idle", 64'(busy), 64'h00);

    // reset mid-flight: R9
    @(negedge clk);
    post(4, 64'hA00F, 2'd3);
    launch();
    rst = 1'b1;
    step();
    rst = 1'b0;
    chk("R9", "reset clears", 64'(sel_valid), 64'd0);
    chk("R9", "reset clears busy", 64'(busy), 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule